// File: doc/BRIEF.md
# Single-Channel DMA Transfer Sequencer

This block is the control and sequencing logic for one DMA channel. Software programs a small register bank (start addresses for the source and destination, a byte count, a control word, a request-line select and a burst length), then sets the enable bit. The channel moves data one beat at a time. Each beat is a read on the memory port, held until acknowledged, followed by a write of the captured data, also held until acknowledged. Each side's address either steps by the beat width or stays fixed, so the same engine serves memory-to-peripheral, peripheral-to-memory and memory-to-memory copies.

Beats are grouped into bursts. When request pacing is enabled, each burst starts only while the selected external request line is high. When a chunk completes, the channel raises a one-cycle done pulse. If the repeat bit is set, the channel reloads the start addresses and count that software last wrote and continues without stopping. This lets software queue the next chunk while the current one runs.

Top module: `dmach_engine`

## Requirements
- R1: The register window sits at byte address 0x80 + CHAN*64, with word offsets 0x00 source, 0x04 destination, 0x08 count (only bits 23:0 kept), 0x0C control, 0x10 request select (low 5 bits), 0x14 burst length (low 6 bits) and 0x1C bytes moved. Offset 0x18, and any address outside the window, read as zero. A write outside the window changes nothing.
- R2: A write that sets control bit 0 while it is clear starts a chunk. It loads both working addresses and the working count from the programmed registers and zeroes the bytes-moved counter.
- R3: Each beat reads first and then writes the read data unchanged. Each request stays high until its acknowledge is seen, and the read and write requests are never high together.
- R4: The beat width is the narrower of the two port sizes. The source size is control bits 5:4 and the destination size is bits 7:6, with code 0 = 4 bytes, 1 = 1 byte and 2 = 2 bytes. The width is driven on `beat_len`.
- R5: A side whose mode code is 0 or 1 steps its address by the beat width after every beat. The step is upward, or downward when control bit 9 is set. A side whose mode code is 2 or 3 keeps its address fixed. The source mode is control bits 11:10 and the destination mode is bits 13:12.
- R6: A burst ends once it has moved at least the burst length in bytes, where a length of 0 means 64. With control bit 3 set, a new burst starts only while the request line chosen by the select register is high, or when control bit 1 is set; bit 1 clears itself as that burst starts. With bit 3 clear, bursts run back to back.
- R7: The bytes-moved counter grows by the beat width per beat. When it reaches the working count, `done` is high for exactly one cycle. Without repeat, control bit 0 then clears and the channel stops.
- R8: With repeat (control bit 2) set, completion reloads the last-written source, destination and count and continues. If control bit 14 is also set, the repeat bit clears at that reload, so the following completion stops the channel.
- R9: A write that clears control bit 0 stops the channel. From the next cycle no request is issued and no further beat or done pulse occurs.
- R10: After reset all registers read zero and no request or done is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| dreq | input | NREQ | External request lines |
| rd_req | output | 1 | Read beat request |
| rd_addr | output | 32 | Read beat address |
| rd_ack | input | 1 | Read beat acknowledge |
| rd_data | input | DW | Read beat data |
| wr_req | output | 1 | Write beat request |
| wr_addr | output | 32 | Write beat address |
| wr_data | output | DW | Write beat data |
| wr_ack | input | 1 | Write beat acknowledge |
| beat_len | output | 3 | Bytes per beat |
| done | output | 1 | One-cycle chunk completion pulse |

## Verification
The cycle-level assertions check the request handshake, which must hold until acknowledged and must drop after a stop. They also check that a fixed-mode address never moves while a linear one always does, and that no burst starts while pacing is on and the chosen line is low. They also cover the effect of a completion on the enable and counter state. Only the bench scenarios can show the complete beat sequence of a chunk: the address arithmetic for every mode, size and direction, the data passed through, and the beat count per burst. The same holds for the preload-then-reload behaviour of repeat, for the force bit and for the register window decode.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  localparam int ADDR_W      = 32;
  localparam int REG_W       = 32;
  localparam int BURST_W     = 6;
  localparam int BANK_BASE   = 128;
  localparam int BANK_STRIDE = 64;

  typedef enum logic [2:0] {ST_IDLE, ST_WAIT, ST_RD, ST_WR, ST_FIN} dmach_state_e;

  typedef enum logic [2:0] {
    OFF_SRC, OFF_DST, OFF_CNT, OFF_CTL, OFF_SEL, OFF_BLEN, OFF_TMO, OFF_CCNT
  } dmach_off_e;

  // bit 14 down to bit 0 of the control word
  typedef struct packed {
    logic       acrpt;
    logic [1:0] dmod;
    logic [1:0] smod;
    logic       dec;
    logic       msel;
    logic [1:0] dsiz;
    logic [1:0] ssiz;
    logic       ren;
    logic       rpt;
    logic       frc;
    logic       en;
  } dmach_ctrl_t;

  localparam int CTRL_W = $bits(dmach_ctrl_t);

  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      2'd1:    return 3'd1;
      2'd2:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [2:0] beat_width(input logic [1:0] s, input logic [1:0] d);
    logic [2:0] a, b;
    a = size_bytes(s);
    b = size_bytes(d);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a,
                                                  input logic hold, input logic dec,
                                                  input logic [2:0] w);
    if (hold) return a;
    return dec ? a - ADDR_W'(w) : a + ADDR_W'(w);
  endfunction

  function automatic logic [BURST_W:0] burst_limit(input logic [BURST_W-1:0] b);
    return (b == '0) ? (BURST_W+1)'(1 << BURST_W) : {1'b0, b};
  endfunction
endpackage

// File: rtl/dmach_regs.sv
module dmach_regs import dmach_pkg::*; #(
  parameter int CHAN   = 0,
  parameter int CFG_AW = 12,
  parameter int CNT_W  = 24,
  parameter int SEL_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic [CNT_W-1:0]  counter,
  input  logic              clr_en,
  input  logic              clr_rpt,
  input  logic              clr_frc,
  output logic              en,
  output logic              frc,
  output logic              rpt,
  output logic              ren,
  output logic              acrpt,
  output logic              src_hold,
  output logic              dst_hold,
  output logic              dec,
  output logic [1:0]        ssiz,
  output logic [1:0]        dsiz,
  output logic [ADDR_W-1:0] src_prog,
  output logic [ADDR_W-1:0] dst_prog,
  output logic [CNT_W-1:0]  count_prog,
  output logic [SEL_W-1:0]  sel,
  output logic [BURST_W-1:0] blen,
  output logic              start,
  output logic              sw_stop
);
  localparam logic [CFG_AW-1:0] BASE = CFG_AW'(BANK_BASE + CHAN * BANK_STRIDE);

  dmach_ctrl_t ctrl_q;
  logic        hit, wr;
  dmach_off_e  off;

  assign hit = (cfg_addr[CFG_AW-1:5] == BASE[CFG_AW-1:5]) && (cfg_addr[1:0] == 2'b00);
  assign off = dmach_off_e'(cfg_addr[4:2]);
  assign wr  = cfg_we && hit;

  assign start   = wr && (off == OFF_CTL) && cfg_wdata[0] && !ctrl_q.en;
  assign sw_stop = wr && (off == OFF_CTL) && !cfg_wdata[0] && ctrl_q.en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      src_prog   <= '0;
      dst_prog   <= '0;
      count_prog <= '0;
      sel        <= '0;
      blen       <= '0;
    end else begin
      if (wr && off == OFF_SRC)  src_prog   <= cfg_wdata;
      if (wr && off == OFF_DST)  dst_prog   <= cfg_wdata;
      if (wr && off == OFF_CNT)  count_prog <= cfg_wdata[CNT_W-1:0];
      if (wr && off == OFF_SEL)  sel        <= cfg_wdata[SEL_W-1:0];
      if (wr && off == OFF_BLEN) blen       <= cfg_wdata[BURST_W-1:0];
      if (wr && off == OFF_CTL) begin
        ctrl_q <= dmach_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
      end else begin
        if (clr_en)  ctrl_q.en  <= 1'b0;
        if (clr_rpt) ctrl_q.rpt <= 1'b0;
        if (clr_frc) ctrl_q.frc <= 1'b0;
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (hit) begin
      unique case (off)
        OFF_SRC:  cfg_rdata = src_prog;
        OFF_DST:  cfg_rdata = dst_prog;
        OFF_CNT:  cfg_rdata = REG_W'(count_prog);
        OFF_CTL:  cfg_rdata = REG_W'(ctrl_q);
        OFF_SEL:  cfg_rdata = REG_W'(sel);
        OFF_BLEN: cfg_rdata = REG_W'(blen);
        OFF_CCNT: cfg_rdata = REG_W'(counter);
        default:  cfg_rdata = '0;
      endcase
    end
  end

  assign en       = ctrl_q.en;
  assign frc      = ctrl_q.frc;
  assign rpt      = ctrl_q.rpt;
  assign ren      = ctrl_q.ren;
  assign acrpt    = ctrl_q.acrpt;
  assign src_hold = ctrl_q.smod[1];
  assign dst_hold = ctrl_q.dmod[1];
  assign dec      = ctrl_q.dec;
  assign ssiz     = ctrl_q.ssiz;
  assign dsiz     = ctrl_q.dsiz;
endmodule

// File: rtl/dmach_addr.sv
module dmach_addr import dmach_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  input  logic              hold,
  input  logic              dec,
  input  logic [2:0]        width,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= load_val;
    else if (step) addr <= next_addr(addr, hold, dec, width);
  end

  assert_fifo_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && hold) |=> $stable(addr));

  assert_linear_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !hold) |=> (addr != $past(addr)));
endmodule

// File: rtl/dmach_seq.sv
module dmach_seq import dmach_pkg::*; #(
  parameter int CNT_W = 24,
  parameter int NREQ  = 32,
  parameter int SEL_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               ren,
  input  logic               frc,
  input  logic               rpt,
  input  logic               acrpt,
  input  logic [CNT_W-1:0]   count_prog,
  input  logic [BURST_W-1:0] blen,
  input  logic [SEL_W-1:0]   sel,
  input  logic [NREQ-1:0]    dreq,
  input  logic               start,
  input  logic               sw_stop,
  input  logic               rd_ack,
  input  logic               wr_ack,
  input  logic [2:0]         width,
  output logic               rd_req,
  output logic               wr_req,
  output logic               done,
  output logic [CNT_W-1:0]   counter,
  output logic               clr_en,
  output logic               clr_rpt,
  output logic               clr_frc,
  output logic               addr_load,
  output logic               addr_step
);
  localparam int BC_W = BURST_W + 2;

  dmach_state_e     state_q, state_d;
  logic [CNT_W-1:0] counter_d, cur_cnt_q, cur_cnt_d;
  logic [BC_W-1:0]  burst_q, burst_d, burst_sum;
  logic [CNT_W:0]   cnt_sum;
  logic             reached, burst_end, go;

  assign cnt_sum   = {1'b0, counter} + (CNT_W+1)'(width);
  assign reached   = cnt_sum >= {1'b0, cur_cnt_q};
  assign burst_sum = burst_q + BC_W'(width);
  assign burst_end = burst_sum >= BC_W'(burst_limit(blen));
  assign go        = !ren || dreq[sel] || frc;

  always_comb begin
    state_d   = state_q;
    counter_d = counter;
    cur_cnt_d = cur_cnt_q;
    burst_d   = burst_q;
    clr_en    = 1'b0;
    clr_rpt   = 1'b0;
    clr_frc   = 1'b0;
    addr_load = 1'b0;
    addr_step = 1'b0;
    if (sw_stop) begin
      state_d = ST_IDLE;
    end else if (start) begin
      state_d   = ST_WAIT;
      addr_load = 1'b1;
      counter_d = '0;
      cur_cnt_d = count_prog;
    end else begin
      unique case (state_q)
        ST_WAIT: begin
          if (counter >= cur_cnt_q) state_d = ST_FIN;
          else if (go) begin
            state_d = ST_RD;
            burst_d = '0;
            clr_frc = frc;
          end
        end
        ST_RD: if (rd_ack) state_d = ST_WR;
        ST_WR: begin
          if (wr_ack) begin
            addr_step = 1'b1;
            counter_d = cnt_sum[CNT_W-1:0];
            burst_d   = burst_sum;
            if (reached)        state_d = ST_FIN;
            else if (burst_end) state_d = ST_WAIT;
            else                state_d = ST_RD;
          end
        end
        ST_FIN: begin
          if (rpt) begin
            addr_load = 1'b1;
            counter_d = '0;
            cur_cnt_d = count_prog;
            clr_rpt   = acrpt;
            state_d   = ST_WAIT;
          end else begin
            clr_en  = 1'b1;
            state_d = ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      counter   <= '0;
      cur_cnt_q <= '0;
      burst_q   <= '0;
    end else begin
      state_q   <= state_d;
      counter   <= counter_d;
      cur_cnt_q <= cur_cnt_d;
      burst_q   <= burst_d;
    end
  end

  assign rd_req = (state_q == ST_RD);
  assign wr_req = (state_q == ST_WR);
  assign done   = (state_q == ST_FIN);

  assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack && !sw_stop) |=> rd_req);

  assert_wr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack && !sw_stop) |=> wr_req);

  assert_paced_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && ren && !dreq[sel] && !frc && !start && !sw_stop) |=> !rd_req);

  assert_done_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rpt && !sw_stop) |=> (!en && !done));

  assert_repeat_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rpt && !sw_stop) |=> (counter == '0));

  assert_stop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_stop |=> (!rd_req && !wr_req && !done));
endmodule

// File: rtl/dmach_engine.sv
module dmach_engine import dmach_pkg::*; #(
  parameter int CHAN   = 0,
  parameter int CFG_AW = 12,
  parameter int NREQ   = 32,
  parameter int CNT_W  = 24,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic [NREQ-1:0]   dreq,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [DW-1:0]     rd_data,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DW-1:0]     wr_data,
  input  logic              wr_ack,
  output logic [2:0]        beat_len,
  output logic              done
);
  localparam int SEL_W = (NREQ > 1) ? $clog2(NREQ) : 1;

  logic en, frc, rpt, ren, acrpt, src_hold, dst_hold, dec;
  logic [1:0] ssiz, dsiz;
  logic [ADDR_W-1:0] src_prog, dst_prog;
  logic [CNT_W-1:0]  count_prog, counter;
  logic [SEL_W-1:0]  sel;
  logic [BURST_W-1:0] blen;
  logic start, sw_stop, clr_en, clr_rpt, clr_frc, addr_load, addr_step;
  logic [2:0] width;
  logic [DW-1:0] data_q;

  logic [1:0][ADDR_W-1:0] side_prog, side_addr;
  logic [1:0]             side_hold;

  assign width     = beat_width(ssiz, dsiz);
  assign beat_len  = width;
  assign side_prog = {dst_prog, src_prog};
  assign side_hold = {dst_hold, src_hold};

  dmach_regs #(.CHAN(CHAN), .CFG_AW(CFG_AW), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata, .counter,
    .clr_en, .clr_rpt, .clr_frc, .en, .frc, .rpt, .ren, .acrpt,
    .src_hold, .dst_hold, .dec, .ssiz, .dsiz, .src_prog, .dst_prog,
    .count_prog, .sel, .blen, .start, .sw_stop
  );

  dmach_seq #(.CNT_W(CNT_W), .NREQ(NREQ), .SEL_W(SEL_W)) u_seq (
    .clk, .rst_n, .en, .ren, .frc, .rpt, .acrpt, .count_prog, .blen, .sel,
    .dreq, .start, .sw_stop, .rd_ack, .wr_ack, .width, .rd_req, .wr_req,
    .done, .counter, .clr_en, .clr_rpt, .clr_frc, .addr_load, .addr_step
  );

  for (genvar s = 0; s < 2; s++) begin : g_side
    dmach_addr u_addr (
      .clk, .rst_n, .load(addr_load), .load_val(side_prog[s]), .step(addr_step),
      .hold(side_hold[s]), .dec, .width, .addr(side_addr[s])
    );
  end

  assign rd_addr = side_addr[0];
  assign wr_addr = side_addr[1];

  always_ff @(posedge clk) begin
    if (!rst_n)               data_q <= '0;
    else if (rd_req && rd_ack) data_q <= rd_data;
  end

  assign wr_data = data_q;
endmodule

// File: tb/test_dmach_engine.sv
module test_dmach_engine;
  localparam int CLK_PERIOD = 10;
  localparam int LOGN = 1024;
  localparam logic [11:0] BASE  = 12'h100;
  localparam logic [11:0] OTHER = 12'h140;

  logic clk = 0, rst_n = 0, cfg_we = 0, rd_ack = 0, wr_ack = 0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata, rd_data = '0, rd_addr, wr_addr, wr_data;
  logic [31:0] dreq = '0;
  logic rd_req, wr_req, done;
  logic [2:0] beat_len;

  int nchk = 0, nerr = 0, nrd = 0, nwr = 0, done_cnt = 0, rlat = 0, wlat = 0;
  logic [31:0] log_ra [LOGN];
  logic [31:0] log_wa [LOGN];
  logic [31:0] log_wd [LOGN];
  logic [2:0]  log_bl [LOGN];

  dmach_engine #(.CHAN(2)) i_dmach_engine (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata, .dreq,
    .rd_req, .rd_addr, .rd_ack, .rd_data, .wr_req, .wr_addr, .wr_data,
    .wr_ack, .beat_len, .done
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mem_val(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h5A00_00A5;
  endfunction

  function automatic int bw(input int code);
    if (code == 1) return 1;
    if (code == 2) return 2;
    return 4;
  endfunction

  function automatic logic [31:0] exp_addr(input logic [31:0] b, input int mode,
                                           input bit dec, input int w, input int i);
    if (mode >= 2) return b;
    if (dec) return b - 32'(i * w);
    return b + 32'(i * w);
  endfunction

  function automatic logic [31:0] mk_ctl(input bit en, input bit frc, input bit rpt,
      input bit ren, input int ssiz, input int dsiz, input bit dec, input int smod,
      input int dmod, input bit acrpt);
    return 32'(en) | (32'(frc) << 1) | (32'(rpt) << 2) | (32'(ren) << 3) |
           (32'(ssiz) << 4) | (32'(dsiz) << 6) | (32'(dec) << 9) |
           (32'(smod) << 10) | (32'(dmod) << 12) | (32'(acrpt) << 14);
  endfunction

  // memory model: acknowledges after a short random delay and logs beats
  always @(negedge clk) begin
    if (!rst_n) begin
      rd_ack = 0;
      wr_ack = 0;
    end else begin
      if (done) done_cnt++;
      if (rd_ack) rd_ack = 0;
      else if (rd_req) begin
        if (rlat == 0) begin
          rd_ack = 1;
          rd_data = mem_val(rd_addr);
          if (nrd < LOGN) log_ra[nrd] = rd_addr;
          nrd++;
          rlat = $urandom_range(2);
        end else rlat--;
      end
      if (wr_ack) wr_ack = 0;
      else if (wr_req) begin
        if (wlat == 0) begin
          wr_ack = 1;
          if (nwr < LOGN) begin
            log_wa[nwr] = wr_addr;
            log_wd[nwr] = wr_data;
            log_bl[nwr] = beat_len;
          end
          nwr++;
          wlat = $urandom_range(2);
        end else wlat--;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic cfg_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
    #1;
  endtask

  task automatic wait_done(input int target);
    for (int k = 0; k < 5000; k++) begin
      if (done_cnt >= target) break;
      @(negedge clk); #1;
    end
    chk(done_cnt >= target, "R7 done not seen", 32'(done_cnt), 32'(target));
  endtask

  task automatic check_beats(input int first, input int n, input logic [31:0] s,
      input logic [31:0] d, input int smod, input int dmod, input bit dec, input int w);
    for (int i = 0; i < n; i++) begin
      chk(log_ra[first+i] == exp_addr(s, smod, dec, w, i), "R5/R2 source address",
          log_ra[first+i], exp_addr(s, smod, dec, w, i));
      chk(log_wa[first+i] == exp_addr(d, dmod, dec, w, i), "R5/R2 destination address",
          log_wa[first+i], exp_addr(d, dmod, dec, w, i));
      chk(log_wd[first+i] == mem_val(exp_addr(s, smod, dec, w, i)), "R3 data passed",
          log_wd[first+i], mem_val(exp_addr(s, smod, dec, w, i)));
      chk(32'(log_bl[first+i]) == 32'(w), "R4 beat width", 32'(log_bl[first+i]), 32'(w));
    end
  endtask

  task automatic run_xfer(input logic [31:0] s, input logic [31:0] d, input int cnt,
      input int blen, input int smod, input int dmod, input int ssiz, input int dsiz,
      input bit dec);
    int b, dc, w;
    logic [31:0] v;
    w = (bw(ssiz) < bw(dsiz)) ? bw(ssiz) : bw(dsiz);
    b = nwr; dc = done_cnt;
    cfg_write(BASE + 12'h00, s);
    cfg_write(BASE + 12'h04, d);
    cfg_write(BASE + 12'h08, 32'(cnt));
    cfg_write(BASE + 12'h14, 32'(blen));
    cfg_write(BASE + 12'h0C, mk_ctl(1, 0, 0, 0, ssiz, dsiz, dec, smod, dmod, 0));
    wait_done(dc + 1);
    cycles(2);
    chk(nwr - b == cnt / w, "R7 beat count", 32'(nwr - b), 32'(cnt / w));
    check_beats(b, cnt / w, s, d, smod, dmod, dec, w);
    cfg_read(BASE + 12'h0C, v);
    chk(v[0] == 1'b0, "R7 enable cleared", v, v & ~32'h1);
    cfg_read(BASE + 12'h1C, v);
    chk(v == 32'(cnt), "R7 bytes moved", v, 32'(cnt));
    chk(done_cnt == dc + 1, "R7 single done", 32'(done_cnt), 32'(dc + 1));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nerr++; nchk++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int b, dc, n, d0;
    void'($urandom(32'd4242));
    cycles(3);
    chk(!rd_req && !wr_req && !done, "R10 outputs idle in reset", {29'b0, rd_req, wr_req, done}, 0);
    @(negedge clk); rst_n = 1;
    cfg_read(BASE + 12'h0C, v);  chk(v == 0, "R10 control reset", v, 0);
    cfg_read(BASE + 12'h1C, v);  chk(v == 0, "R10 counter reset", v, 0);
    cfg_read(BASE + 12'h00, v);  chk(v == 0, "R10 source reset", v, 0);

    // register window
    cfg_write(BASE + 12'h00, 32'h1234_5678);
    cfg_read(BASE + 12'h00, v);  chk(v == 32'h1234_5678, "R1 source readback", v, 32'h1234_5678);
    cfg_write(BASE + 12'h08, 32'hFFFF_FFFF);
    cfg_read(BASE + 12'h08, v);  chk(v == 32'h00FF_FFFF, "R1 count masked", v, 32'h00FF_FFFF);
    cfg_write(BASE + 12'h10, 32'h25);
    cfg_read(BASE + 12'h10, v);  chk(v == 32'h5, "R1 select masked", v, 32'h5);
    cfg_write(BASE + 12'h14, 32'h47);
    cfg_read(BASE + 12'h14, v);  chk(v == 32'h7, "R1 burst masked", v, 32'h7);
    cfg_write(OTHER + 12'h00, 32'hDEAD_BEEF);
    cfg_read(BASE + 12'h00, v);  chk(v == 32'h1234_5678, "R1 foreign write ignored", v, 32'h1234_5678);
    cfg_read(OTHER + 12'h00, v); chk(v == 0, "R1 foreign read zero", v, 0);
    cfg_read(BASE + 12'h18, v);  chk(v == 0, "R1 offset 0x18 zero", v, 0);

    // directed transfers
    run_xfer(32'h0000_2000, 32'h0000_3000, 16, 0, 0, 0, 0, 0, 0);
    run_xfer(32'h0000_2100, 32'h0000_A000, 8, 4, 0, 2, 1, 0, 1);
    run_xfer(32'h0000_2200, 32'h0000_3200, 12, 2, 3, 1, 2, 2, 0);

    // random transfers
    for (int t = 0; t < 12; t++) begin
      int sm, dm, ss, ds, w, cnt;
      bit dc1;
      sm = $urandom_range(3); dm = $urandom_range(3);
      ss = $urandom_range(2); ds = $urandom_range(2);
      dc1 = 1'($urandom_range(1));
      w = (bw(ss) < bw(ds)) ? bw(ss) : bw(ds);
      cnt = w * (1 + $urandom_range(5));
      run_xfer(32'h0001_0000 | ($urandom & 32'hFFF0), 32'h0004_0000 | ($urandom & 32'hFFF0),
               cnt, $urandom_range(63), sm, dm, ss, ds, dc1);
    end

    // request pacing, burst length and force
    b = nwr; dc = done_cnt;
    cfg_write(BASE + 12'h00, 32'h0000_5000);
    cfg_write(BASE + 12'h04, 32'h0000_6000);
    cfg_write(BASE + 12'h08, 32);
    cfg_write(BASE + 12'h10, 5);
    cfg_write(BASE + 12'h14, 8);
    cfg_write(BASE + 12'h0C, mk_ctl(1, 0, 0, 1, 0, 0, 0, 0, 0, 0));
    cycles(30);
    chk(nwr == b, "R6 no burst without request", 32'(nwr - b), 0);
    @(negedge clk); dreq[5] = 1;
    @(negedge clk); dreq[5] = 0;
    cycles(60);
    chk(nwr - b == 2, "R6 one burst of 8 bytes", 32'(nwr - b), 2);
    @(negedge clk); dreq[4] = 1;
    cycles(60);
    chk(nwr - b == 2, "R6 unselected line ignored", 32'(nwr - b), 2);
    @(negedge clk); dreq[4] = 0;
    cfg_write(BASE + 12'h0C, mk_ctl(1, 1, 0, 1, 0, 0, 0, 0, 0, 0));
    cycles(60);
    chk(nwr - b == 4, "R6 forced burst", 32'(nwr - b), 4);
    cfg_read(BASE + 12'h0C, v);
    chk(v[1] == 1'b0, "R6 force self-clears", v, v & ~32'h2);
    @(negedge clk); dreq[5] = 1;
    wait_done(dc + 1);
    cycles(2);
    chk(nwr - b == 8, "R6 paced chunk completes", 32'(nwr - b), 8);
    check_beats(b, 8, 32'h0000_5000, 32'h0000_6000, 0, 0, 0, 4);
    @(negedge clk); dreq[5] = 0;

    // repeat with auto-clear: preload second chunk while first waits
    b = nwr; dc = done_cnt;
    cfg_write(BASE + 12'h00, 32'h0000_4000);
    cfg_write(BASE + 12'h04, 32'h0000_4800);
    cfg_write(BASE + 12'h08, 16);
    cfg_write(BASE + 12'h10, 3);
    cfg_write(BASE + 12'h14, 0);
    cfg_write(BASE + 12'h0C, mk_ctl(1, 0, 1, 1, 0, 0, 0, 0, 0, 1));
    cfg_write(BASE + 12'h00, 32'h0000_7000);
    cfg_write(BASE + 12'h04, 32'h0000_7800);
    cfg_write(BASE + 12'h08, 8);
    @(negedge clk); dreq[3] = 1;
    wait_done(dc + 2);
    cycles(2);
    chk(nwr - b == 6, "R8 beats over two chunks", 32'(nwr - b), 6);
    check_beats(b, 4, 32'h0000_4000, 32'h0000_4800, 0, 0, 0, 4);
    check_beats(b + 4, 2, 32'h0000_7000, 32'h0000_7800, 0, 0, 0, 4);
    cfg_read(BASE + 12'h0C, v);
    chk(v[2] == 1'b0 && v[0] == 1'b0, "R8 repeat and enable cleared", v, v & ~32'h5);
    n = nwr;
    cycles(40);
    chk(nwr == n && done_cnt == dc + 2, "R8 stops after second chunk", 32'(nwr - n), 0);
    @(negedge clk); dreq[3] = 0;

    // stop mid-transfer
    dc = done_cnt; b = nwr;
    cfg_write(BASE + 12'h00, 32'h0000_8000);
    cfg_write(BASE + 12'h04, 32'h0000_9000);
    cfg_write(BASE + 12'h08, 64);
    cfg_write(BASE + 12'h0C, mk_ctl(1, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    for (int k = 0; k < 500 && nwr - b < 3; k++) begin
      @(negedge clk); #1;
    end
    cfg_write(BASE + 12'h0C, 0);
    cycles(5);
    chk(!rd_req && !wr_req, "R9 requests dropped", {30'b0, rd_req, wr_req}, 0);
    n = nwr; d0 = done_cnt;
    cycles(40);
    chk(nwr == n, "R9 no beats after stop", 32'(nwr - n), 0);
    chk(d0 == dc && done_cnt == dc, "R9 no done after stop", 32'(done_cnt - dc), 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule